// File: doc/BRIEF.md
# Ethernet MAC Channel Stop/Start Controller

This block holds the run state of the two data channels of an Ethernet MAC, transmit and receive, behind a single mode register. Software turns a channel on or off by writing its enable bit. Turning a channel off is graceful. A frame that has already begun is allowed to finish. The channel reports that it has come to rest through a read-only idle flag, which rises only once no frame is in flight. The frame engines report their activity through start and end strobes, and the block gives each of them a run output that tells it whether it may begin a new frame.

A channel that is switched back on before its earlier stop has completed does not restart at once. The request is held and applied on the clock after the idle flag rises, so an old frame never overlaps a fresh start. A self-clearing soft-reset bit returns everything to the power-up state over a fixed number of cycles. While that reset runs, the bit reads back as 1 and other writes are dropped. Each channel needs about one frame time to stop: roughly 1.2 ms at 10 Mb/s, 124 us at 100 Mb/s, and 13 us at 1 Gb/s, or 73 us at 1 Gb/s with jumbo frames.

Top module: `mac_chan_stop_ctrl`

## Requirements
- R1: The mode register has these fields: bit 0 is transmit enable, bit 1 is receive enable, bit 2 is soft reset, bit 3 is the transmit idle flag and bit 4 is the receive idle flag. `rd_data` shows the state of the register one clock after that state is reached.
- R2: Writing 1 to the enable bit of an idle, stopped channel sets its run output on that clock edge and clears its idle flag.
- R3: Clearing an enable bit while the channel has no frame in flight sets its idle flag on the same edge that drops run, so the flag is readable on the next clock.
- R4: Clearing an enable bit while a frame is in flight drops run at once. The idle flag stays 0 until the edge that samples the frame-end strobe, and it rises on that edge.
- R5: Writing 1 to an enable bit while the channel is stopped but not yet idle is held off. The channel stays off until its idle flag has been set, and it turns on at the following edge.
- R6: Writing 1 to an enable bit that is already set changes nothing. The run output, the idle flag and the frame-in-flight state are all unaffected.
- R7: A frame-start strobe is ignored while the channel's run output is 0.
- R8: Writing 1 to bit 2 starts a soft reset. The bit reads 1 for 16 cycles and then clears by itself. The reset forces both channels off with both idle flags set, and every write made during it is ignored.
- R9: The transmit and receive channels stop and start independently of each other.
- R10: The synchronous active-high `rst` puts both channels off and both idle flags set, so the register reads 5'b11000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 5 | Write value; only bits 0 to 2 act |
| rd_data | output | 5 | Registered readback of the mode register |
| tx_frm_start | input | 1 | Transmit frame begins |
| tx_frm_end | input | 1 | Transmit frame ends |
| rx_frm_start | input | 1 | Receive frame begins |
| rx_frm_end | input | 1 | Receive frame ends |
| tx_run | output | 1 | Transmit channel may begin frames |
| rx_run | output | 1 | Receive channel may begin frames |

## Verification
The bench disables a channel in the middle of a frame and checks that the idle flag stays low until the end strobe. A design that flags idle at the moment of the write would fail this check. It re-enables a channel during a stop that is still pending and checks the exact cycle on which run returns. A design that restarts early would show run while the old frame is still in flight, and one that forgets the request would never restart. It sends a frame-start strobe while the channel is off and then toggles the enable. If that stale start had been accepted, the idle flag would stall. Finally, it checks the length of the soft reset and that a write made during it is dropped. An off-by-one counter, or a write that leaks through, shows up in the readback.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int MODE_W    = 5;
  localparam int NCH       = 2;
  localparam int TX_EN_B   = 0;
  localparam int RX_EN_B   = 1;
  localparam int SRST_B    = 2;
  localparam int TX_IDLE_B = 3;
  localparam int RX_IDLE_B = 4;
  localparam int EN_BASE   = TX_EN_B;
  localparam int IDLE_BASE = TX_IDLE_B;
endpackage

// File: rtl/mcs_srst_seq.sv
module mcs_srst_seq #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (kick && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYC - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  srst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q == '0 && !kick) |=> !busy);
  // R8
  srst_start_chk: assert property (@(posedge clk) disable iff (rst)
    (kick && !busy) |=> busy);
endmodule

// File: rtl/mcs_chan_gate.sv
module mcs_chan_gate (
  input  logic clk,
  input  logic clr,
  input  logic wr_stb,
  input  logic wr_val,
  input  logic frm_start,
  input  logic frm_end,
  output logic run,
  output logic idle
);
  logic in_frm_q, pend_q;
  logic en_nx, in_nx, pend_nx;

  always_comb begin
    en_nx   = run;
    pend_nx = pend_q;
    if (wr_stb) begin
      if (!wr_val) begin
        en_nx   = 1'b0;
        pend_nx = 1'b0;
      end else if (!run) begin
        if (idle) begin
          en_nx   = 1'b1;
          pend_nx = 1'b0;
        end else begin
          pend_nx = 1'b1;
        end
      end
    end else if (pend_q && idle) begin
      en_nx   = 1'b1;
      pend_nx = 1'b0;
    end
    in_nx = in_frm_q;
    if (frm_start && run) in_nx = 1'b1;
    else if (frm_end)     in_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      run      <= 1'b0;
      idle     <= 1'b1;
      in_frm_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      run      <= en_nx;
      in_frm_q <= in_nx;
      pend_q   <= pend_nx;
      idle     <= !en_nx && !in_nx;
    end
  end

  // R2
  run_idle_excl_chk: assert property (@(posedge clk) disable iff (clr)
    !(run && idle));
  // R7
  start_gated_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(in_frm_q) |-> $past(run));
  // R4
  idle_after_frame_chk: assert property (@(posedge clk) disable iff (clr)
    idle |-> !in_frm_q);
  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (pend_q && !idle) |=> !run);
endmodule

// File: rtl/mac_chan_stop_ctrl.sv
module mac_chan_stop_ctrl
  import mcs_pkg::*;
#(
  parameter int SRST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] rd_data,
  input  logic              tx_frm_start,
  input  logic              tx_frm_end,
  input  logic              rx_frm_start,
  input  logic              rx_frm_end,
  output logic              tx_run,
  output logic              rx_run
);
  logic           busy, kick, wr_ok, chan_clr;
  logic [NCH-1:0] st_v, en_v, run_v, idle_v;

  assign kick     = wr_en && wr_data[SRST_B];
  assign wr_ok    = wr_en && !wr_data[SRST_B] && !busy;
  assign chan_clr = rst || busy || (kick && !busy);
  assign st_v     = {rx_frm_start, tx_frm_start};
  assign en_v     = {rx_frm_end, tx_frm_end};

  mcs_srst_seq #(.CYC(SRST_CYC)) srst_i (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mcs_chan_gate gate_i (
      .clk(clk), .clr(chan_clr), .wr_stb(wr_ok),
      .wr_val(wr_data[EN_BASE + c]),
      .frm_start(st_v[c]), .frm_end(en_v[c]),
      .run(run_v[c]), .idle(idle_v[c])
    );
  end

  assign tx_run = run_v[0];
  assign rx_run = run_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_data[TX_IDLE_B] <= 1'b1;
      rd_data[RX_IDLE_B] <= 1'b1;
    end else begin
      rd_data <= '0;
      rd_data[TX_EN_B]   <= run_v[0];
      rd_data[RX_EN_B]   <= run_v[1];
      rd_data[SRST_B]    <= busy;
      rd_data[TX_IDLE_B] <= idle_v[0];
      rd_data[RX_IDLE_B] <= idle_v[1];
    end
  end

  // R8
  srst_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idle_v == '1 && run_v == '0));
  // R8
  srst_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(run_v));
endmodule

// File: tb/mac_chan_stop_ctrl_tb_top.sv
module mac_chan_stop_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic tx_fs = 0, tx_fe = 0, rx_fs = 0, rx_fe = 0;
  logic tx_run, rx_run;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mac_chan_stop_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_frm_start(tx_fs), .tx_frm_end(tx_fe),
    .rx_frm_start(rx_fs), .rx_frm_end(rx_fe),
    .tx_run(tx_run), .rx_run(rx_run)
  );

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tx_start(); @(negedge clk); tx_fs = 1; @(negedge clk); tx_fs = 0; endtask
  task automatic pulse_tx_end();   @(negedge clk); tx_fe = 1; @(negedge clk); tx_fe = 0; endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 reset readback", rd_data, 5'b11000);
    chk("R10 reset run", {3'b0, rx_run, tx_run}, 5'b0);
    wr(5'b00011); settle();
    rst = 1'b1; @(negedge clk); rst = 1'b0; settle();
    chk("R10 reset while running", rd_data, 5'b11000);
  endtask

  task automatic t_enable();
    do_reset();
    wr(5'b00001);
    chk("R2 tx_run after enable", {4'b0, tx_run}, 5'b1);
    settle();
    chk("R2 R1 readback tx enabled", rd_data, 5'b10001);
  endtask

  task automatic t_stop_idle_now();
    do_reset();
    wr(5'b00010); settle();
    chk("R1 rx enabled readback", rd_data, 5'b01010);
    wr(5'b00000); settle();
    chk("R3 idle on next clock", rd_data, 5'b11000);
  endtask

  task automatic t_stop_in_frame();
    do_reset();
    wr(5'b00001); pulse_tx_start();
    wr(5'b00000); settle();
    chk("R4 idle held during frame", rd_data, 5'b10000);
    repeat (5) @(negedge clk);
    chk("R4 idle still held", rd_data, 5'b10000);
    pulse_tx_end(); settle();
    chk("R4 idle after frame end", rd_data, 5'b11000);
  endtask

  task automatic t_reenable_pending();
    do_reset();
    wr(5'b00001); pulse_tx_start();
    wr(5'b00000);
    wr(5'b00001); settle();
    chk("R5 re-enable held off", rd_data, 5'b10000);
    chk("R5 run held off", {4'b0, tx_run}, 5'b0);
    pulse_tx_end();
    settle();
    chk("R5 idle seen before restart", rd_data, 5'b11000);
    settle();
    chk("R5 restart after idle", rd_data, 5'b10001);
  endtask

  task automatic t_reenable_noop();
    do_reset();
    wr(5'b00001); pulse_tx_start();
    wr(5'b00001); settle();
    chk("R6 repeat enable no change", rd_data, 5'b10001);
    wr(5'b00000); settle();
    chk("R6 frame state kept", rd_data, 5'b10000);
    pulse_tx_end(); settle();
    chk("R6 idle after end", rd_data, 5'b11000);
  endtask

  task automatic t_start_ignored();
    do_reset();
    pulse_tx_start();
    wr(5'b00001);
    wr(5'b00000); settle();
    chk("R7 stale start ignored", rd_data, 5'b11000);
  endtask

  task automatic t_soft_reset();
    do_reset();
    wr(5'b00011); settle();
    chk("R9 both enabled", rd_data, 5'b00011);
    wr(5'b00100);
    repeat (3) @(negedge clk);
    wr(5'b00011);
    repeat (11) @(negedge clk);
    chk("R8 busy through cycle 16", rd_data, 5'b11100);
    chk("R8 channels off", {3'b0, rx_run, tx_run}, 5'b0);
    settle();
    chk("R8 self clear and write dropped", rd_data, 5'b11000);
  endtask

  task automatic t_independent();
    do_reset();
    wr(5'b00011); pulse_tx_start();
    wr(5'b00000); settle();
    chk("R9 rx idle, tx waits", rd_data, 5'b10000);
    pulse_tx_end(); settle();
    chk("R9 both idle", rd_data, 5'b11000);
  endtask

  initial begin
    t_reset_state();
    t_enable();
    t_stop_idle_now();
    t_stop_in_frame();
    t_reenable_pending();
    t_reenable_noop();
    t_start_ignored();
    t_soft_reset();
    t_independent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule